// File: doc/BRIEF.md
# USB Clock Source Divider and Gate

This block derives the clock for a USB device core from one of two PLL outputs. A configuration register chooses the PLL and holds a 4-bit divide code. The divide ratio is the code plus one, so the ratio runs from 1 to 16. Software turns the clock on by writing a one to a set register and turns it off by writing a one to a clear register. A status register reads back the current enable state.

The enable only reaches the output while the selected PLL reports lock. The enable is resynchronised into the source clock domain. A change of gate state is applied only at a period boundary of the divided clock, while the output is low, so the consumer never sees a shortened pulse.

The source select and the divide code are quasi-static. Software changes them only while the clock is disabled and the output has gone low. The register port and the source-domain logic share one synchronous active-low reset. That reset is held for several cycles of the slower source clock.

Top module: `usb_clk_gen`

## Requirements
- R1: After reset the configuration register reads 0 (source select 0, divide code 0), the status register reads 0 and `usb_clk` is low.
- R2: Configuration bit 0 selects the source: 0 takes `pll_a_clk` and 1 takes `pll_b_clk`, and the output period follows the selected clock.
- R3: The divide code sits in configuration bits 7:4 and reads back as written. The output period is (code+1) source periods.
- R4: For ratios of 2 or more, the high phase lasts floor(ratio/2) source periods. An odd ratio therefore has a high phase one source period shorter than its low phase.
- R5: With code 0 (ratio 1), `usb_clk` follows the selected source clock: high for half a source period and with the same period.
- R6: Writing bit 0 = 1 to the set register (address 1) enables the clock, and status bit 0 (address 3) then reads 1.
- R7: Writing bit 0 = 1 to the clear register (address 2) disables the clock. Status reads 0 and `usb_clk` stays low with no further rising edge.
- R8: Writing bit 0 = 0 to the set or clear register leaves the enable state and the output activity unchanged.
- R9: While the selected PLL's lock is low, `usb_clk` is held low even when enabled, and status still reads the enable bit. The lock of the unselected PLL has no effect. The clock resumes once lock returns.
- R10: Gating changes only at a period boundary. A rising edge of the divided output starts a full high phase, and a falling edge occurs only after the full high phase, unless lock was lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Register port clock |
| rst_n | input | 1 | Synchronous active-low reset for both domains |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 config, 1 set, 2 clear, 3 status |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| pll_a_clk | input | 1 | First PLL clock |
| pll_b_clk | input | 1 | Second PLL clock |
| pll_a_lock | input | 1 | Lock indication of the first PLL |
| pll_b_lock | input | 1 | Lock indication of the second PLL |
| usb_clk | output | 1 | Divided, gated USB clock |

## Verification
The bench measures the high phase and the period of the first pulse after each enable, across both sources and both odd and even ratios. A design with an off-by-one counter would show the wrong period. One that centred odd ratios wrongly would show a high phase equal to or longer than the low phase. One that gated mid-period would show a short first pulse. Ratio 1 is checked separately, because a design that sent it through the counter would output nothing or half the frequency. Zero writes to set and clear, and lock loss on the selected versus the unselected PLL, are checked by counting output edges over a window. A design that decoded the write data loosely or sampled the wrong lock would keep toggling or stop when it should not.

// File: rtl/usbck_pkg.sv
`timescale 1ns/1ps
// Package: shared register addresses and field positions for the USB clock generator.
package usbck_pkg;
    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_SET  = 2'd1,
        REG_CLR  = 2'd2,
        REG_STAT = 2'd3
    } usbck_addr_e;

    localparam int SEL_BIT = 0;   // source select bit in config
    localparam int EN_BIT  = 0;   // enable bit in set/clear/status
    localparam int DIV_LSB = 4;   // lowest bit of the divide code in config
endpackage

// File: rtl/usbck_sync.sv
`timescale 1ns/1ps
// Module: usbck_sync
// Multi-flop synchronizer bringing a level into the destination clock domain.
// Assumes the input is a slowly changing level; STAGES must be at least 2.
module usbck_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the level through the flop chain; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/usbck_regs.sv
`timescale 1ns/1ps
// Module: usbck_regs
// Register port: config (select + divide code), write-one set/clear of the
// enable, and a status read of the enable. Assumes one access per cycle.
module usbck_regs
    import usbck_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             sel,
    output logic [DIV_W-1:0] div,
    output logic             en
);
    // Update config and enable on writes; zero bits of set/clear are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= 1'b0;
            div <= '0;
            en  <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                REG_CFG: begin
                    sel <= wdata[SEL_BIT];
                    div <= wdata[DIV_LSB +: DIV_W];
                end
                REG_SET: if (wdata[EN_BIT]) en <= 1'b1;
                REG_CLR: if (wdata[EN_BIT]) en <= 1'b0;
                default: ;
            endcase
        end
    end

    // Read mux: config fields or enable status; set/clear read as zero.
    always_comb begin
        rdata = '0;
        case (addr)
            REG_CFG: begin
                rdata[SEL_BIT]           = sel;
                rdata[DIV_LSB +: DIV_W]  = div;
            end
            REG_STAT: rdata[EN_BIT] = en;
            default: ;
        endcase
    end

    a_r6_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_SET && wdata[EN_BIT]) |=> en);
    a_r7_clr_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_CLR && wdata[EN_BIT]) |=> !en);
    a_r8_zero_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == REG_SET || addr == REG_CLR) && !wdata[EN_BIT]) |=> $stable(en));
endmodule

// File: rtl/usbck_divgate.sv
`timescale 1ns/1ps
// Module: usbck_divgate
// Divides the selected source clock by (div+1) and gates it. The gate state
// is taken only at the start of a divided period; ratio 1 bypasses the counter
// and gates the raw source on its low phase. Assumes div is static while enabled.
module usbck_divgate #(
    parameter int DIV_W = 4
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             en_s,
    input  logic             lock_s,
    output logic             clk_out
);
    logic [DIV_W-1:0] cnt, cnt_nx;
    logic [DIV_W:0]   hi_len;
    logic             gate_q, gate_nx, out_q, gate_n;

    // Next count and high-phase length of the current ratio.
    always_comb begin
        hi_len  = ({1'b0, div} + 1'b1) >> 1;
        cnt_nx  = (cnt >= div) ? '0 : cnt + 1'b1;
        gate_nx = (cnt_nx == '0) ? (en_s & lock_s) : gate_q;
    end

    // Period counter, boundary-aligned gate and registered divided output.
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            cnt    <= '0;
            gate_q <= 1'b0;
            out_q  <= 1'b0;
        end else begin
            cnt    <= cnt_nx;
            gate_q <= gate_nx;
            out_q  <= gate_nx & lock_s & ({1'b0, cnt_nx} < hi_len);
        end
    end

    // Ratio-1 gate, updated while the source is low so no runt pulse passes.
    always_ff @(negedge clk_src) begin
        if (!rst_n) gate_n <= 1'b0;
        else        gate_n <= en_s & lock_s;
    end

    assign clk_out = (div == '0) ? (clk_src & gate_n) : out_q;

    a_r10_rise_at_start: assert property (@(posedge clk_src) disable iff (!rst_n)
        $rose(out_q) |-> (cnt == '0));
    a_r4_fall_after_high: assert property (@(posedge clk_src) disable iff (!rst_n)
        ($fell(out_q) && $past(lock_s)) |-> ({1'b0, cnt} == hi_len));
    a_r9_unlock_low: assert property (@(posedge clk_src) disable iff (!rst_n)
        !lock_s |=> !out_q);
endmodule

// File: rtl/usb_clk_gen.sv
`timescale 1ns/1ps
// Module: usb_clk_gen (top)
// Selects one of two PLL clocks, divides it by 1..16 and gates it under a
// software enable qualified by the selected PLL lock. Assumes select and
// divide code change only while disabled, and rst_n spans several source cycles.
module usb_clk_gen #(
    parameter int DW     = 8,
    parameter int DIV_W  = 4,
    parameter int STAGES = 2
) (
    input  logic          pclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          pll_a_clk,
    input  logic          pll_b_clk,
    input  logic          pll_a_lock,
    input  logic          pll_b_lock,
    output logic          usb_clk
);
    logic             sel, en, en_s, lock_s, clk_src, lock_sel;
    logic [DIV_W-1:0] div;

    usbck_regs #(.DW(DW), .DIV_W(DIV_W)) u_regs (
        .clk(pclk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sel(sel), .div(div), .en(en)
    );

    // Source and lock chosen by the select bit.
    assign clk_src  = sel ? pll_b_clk  : pll_a_clk;
    assign lock_sel = sel ? pll_b_lock : pll_a_lock;

    usbck_sync #(.STAGES(STAGES)) u_sync_en (
        .clk(clk_src), .rst_n(rst_n), .d(en), .q(en_s)
    );
    usbck_sync #(.STAGES(STAGES)) u_sync_lock (
        .clk(clk_src), .rst_n(rst_n), .d(lock_sel), .q(lock_s)
    );

    usbck_divgate #(.DIV_W(DIV_W)) u_div (
        .clk_src(clk_src), .rst_n(rst_n), .div(div), .en_s(en_s),
        .lock_s(lock_s), .clk_out(usb_clk)
    );
endmodule

// File: tb/tb_usb_clk_gen.sv
`timescale 1ns/1ps
module tb_usb_clk_gen;
    localparam int CLK_PERIOD = 20;
    localparam int TA = 10;
    localparam int TB = 14;
    localparam int NVEC = 8;
    // Each entry: {select, divide code}
    localparam logic [4:0] VEC [NVEC] = '{
        5'b0_0000, 5'b0_0001, 5'b0_0010, 5'b1_0011,
        5'b1_0100, 5'b0_1111, 5'b1_0000, 5'b0_0111
    };

    logic       pclk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0, rdata;
    logic       pll_a_clk = 1'b0, pll_b_clk = 1'b0;
    logic       pll_a_lock = 1'b1, pll_b_lock = 1'b1;
    logic       usb_clk;
    int         nchk = 0, nerr = 0, edges = 0;

    usb_clk_gen dut (
        .pclk(pclk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pll_a_clk(pll_a_clk), .pll_b_clk(pll_b_clk),
        .pll_a_lock(pll_a_lock), .pll_b_lock(pll_b_lock), .usb_clk(usb_clk)
    );

    always #(CLK_PERIOD/2) pclk = ~pclk;
    always #(TA/2) pll_a_clk = ~pll_a_clk;
    always #(TB/2) pll_b_clk = ~pll_b_clk;
    always @(posedge usb_clk) edges++;

    task automatic chk(input string req, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge pclk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge pclk); wr_en = 1'b0; wdata = 8'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge pclk); addr = a; #1; d = rdata;
    endtask

    task automatic measure(output longint hi, output longint per);
        longint t0, t1, t2;
        @(posedge usb_clk); t0 = $time;
        @(negedge usb_clk); t1 = $time;
        @(posedge usb_clk); t2 = $time;
        hi = t1 - t0; per = t2 - t0;
    endtask

    // Returns edges seen over a quiet window and the output level at its end.
    task automatic quiet(output int de, output logic lvl);
        int e0;
        e0 = edges; #600; de = edges - e0; lvl = usb_clk;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        longint hi, per;
        int de;
        logic lvl;
        repeat (10) @(negedge pclk);
        rst_n = 1'b1;
        // R1: reset state
        rd(2'd0, d); chk("R1 cfg", d, 0);
        rd(2'd3, d); chk("R1 status", d, 0);
        quiet(de, lvl); chk("R1 edges", de, 0); chk("R1 level", lvl, 0);

        // Table walk: R2, R3, R4, R5, R6, R10
        for (int i = 0; i < NVEC; i++) begin
            int n, t;
            wr(2'd2, 8'h01);
            #400;
            wr(2'd0, {VEC[i][3:0], 3'b000, VEC[i][4]});
            rd(2'd0, d);
            chk("R3 cfg readback", d, {VEC[i][3:0], 3'b000, VEC[i][4]});
            wr(2'd1, 8'h01);
            rd(2'd3, d); chk("R6 status on", d, 1);
            n = VEC[i][3:0] + 1;
            t = VEC[i][4] ? TB : TA;
            measure(hi, per);
            chk(VEC[i][4] ? "R2 R3 period srcB" : "R2 R3 period srcA", per, n * t);
            if (n == 1) chk("R5 bypass high", hi, t / 2);
            else        chk("R4 R10 high phase", hi, (n / 2) * t);
        end

        // R8: zero writes ignored while enabled (currently sel=0, div=7)
        wr(2'd2, 8'h00); wr(2'd1, 8'h00);
        rd(2'd3, d); chk("R8 status kept on", d, 1);
        quiet(de, lvl); chk("R8 still toggling", de > 0, 1);

        // R7: clear stops the clock
        wr(2'd2, 8'h01);
        rd(2'd3, d); chk("R7 status off", d, 0);
        #400;
        quiet(de, lvl); chk("R7 no edges", de, 0); chk("R7 low", lvl, 0);

        // R8: zero set write while disabled
        wr(2'd1, 8'hFE);
        rd(2'd3, d); chk("R8 status kept off", d, 0);
        quiet(de, lvl); chk("R8 no edges", de, 0);

        // R9: selected lock low holds output low; unselected lock ignored
        wr(2'd0, 8'h20);            // sel 0, code 2
        wr(2'd1, 8'h01);
        pll_b_lock = 1'b0;
        #200;
        quiet(de, lvl); chk("R9 other lock ignored", de > 0, 1);
        pll_b_lock = 1'b1;
        pll_a_lock = 1'b0;
        #200;
        quiet(de, lvl); chk("R9 unlocked edges", de, 0); chk("R9 unlocked low", lvl, 0);
        rd(2'd3, d); chk("R9 status while unlocked", d, 1);
        pll_a_lock = 1'b1;
        #200;
        measure(hi, per);
        chk("R9 resume period", per, 3 * TA);
        chk("R9 R10 resume high", hi, TA);

        summary();
        $finish;
    end
endmodule